// File: doc/BRIEF.md
# Capture-Reload Timer with Baud Mode

This peripheral holds a 16-bit count and a 16-bit capture/reload value. It is programmed through a byte-wide register bus. The count advances on one of three sources: an internal tick enable, falling edges on an external count pin, or every second clock when the block makes baud ticks. A second external pin, the trigger, can take a snapshot of the count into the capture/reload register or load the count from it. An up/down mode counts in either direction. In that mode the external flag flips on every wrap, which makes it act as a seventeenth count bit.

When either baud-select bit is set, the block always reloads on overflow and counts at half the clock rate. Each wrap then gives a one-cycle pulse on the receive tick, the transmit tick, or both. In this mode the overflow flag stays clear and the trigger pin has no effect. Both pins pass through synchronizers before their edges are detected. The interrupt request reflects the two status flags.

Top module: `crt_timer`

## Requirements
- R1: While reset is held and after it is released, the control register, the count and the capture/reload register read 0, and irq, rx_tick and tx_tick are 0.
- R2: Address 0 is the control register, with bit 7 the overflow flag, bit 6 the external flag, bit 5 the receive-baud select, bit 4 the transmit-baud select, bit 3 the trigger enable, bit 2 run, bit 1 the source select (1 selects the count pin) and bit 0 the mode select (1 = capture, 0 = reload). Addresses 1 and 2 hold the count low and high bytes, and addresses 3 and 4 hold the capture/reload low and high bytes. All of these can be written and read back.
- R3: With run at 1, the source select at 0 and no baud select set, the count goes up by one on each clock that has tick_en high.
- R4: With the source select at 1, the count goes up by one on each falling edge of cnt_pin and ignores tick_en.
- R5: With run at 0, the count does not change.
- R6: Counting up from FFFFh sets the overflow flag. The count then becomes 0000h in capture mode, or takes the capture/reload value in reload mode.
- R7: With updn_en at 1 and reload mode selected, cnt_up at 0 makes the count go down. A step taken while the count equals the capture/reload value loads FFFFh. Every wrap in either direction sets the overflow flag and inverts the external flag. In this mode the external flag does not drive irq.
- R8: In capture mode with the trigger enable at 1, a falling edge on trig_pin copies the count into the capture/reload register and sets the external flag.
- R9: In reload mode with the trigger enable at 1 and updn_en at 0, a falling edge on trig_pin loads the count from the capture/reload register and sets the external flag. With the trigger enable at 0, trigger edges change neither the count, the capture/reload value nor the flags.
- R10: When either baud select is 1 and run is 1, the count steps every second clock and reloads from the capture/reload register on each wrap. Each wrap gives a one-cycle pulse on rx_tick if the receive select is set, and on tx_tick if the transmit select is set. The overflow flag is never set in this mode, and tick_en is ignored.
- R11: irq is the OR of the overflow flag and the external flag, with the external flag left out in up/down mode. A software write of 1 to either flag raises irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| tick_en | input | 1 | Internal count enable for timer mode |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| trig_pin | input | 1 | External capture/reload trigger pin (asynchronous) |
| updn_en | input | 1 | Enables up/down counting in reload mode |
| cnt_up | input | 1 | Count direction in up/down mode (1 = up) |
| irq | output | 1 | Interrupt request |
| rx_tick | output | 1 | Receive baud tick pulse |
| tx_tick | output | 1 | Transmit baud tick pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit count, two synchronizer stages and a 3-bit address. Because the count registers can be written directly, every wrap and every compare-equal boundary can be reached within a few steps of a preloaded value. The direction, reload and flag interactions therefore all fit in short vectors. With two sync stages, a pin edge reaches the count three clocks later, so the pin tests wait a fixed, short settle time before reading back.

// File: rtl/crt_pkg.sv
package crt_pkg;
  typedef struct packed {
    logic ovf;
    logic ext;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
    logic ct_sel;
    logic cap_sel;
  } ctrl_t;

  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned CNT_BASE  = 1;
endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              last_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      last_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      last_q <= sh_q[STAGES-1];
    end
  end

  assign fall = last_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import crt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       wrap,
  input  logic       ext_set,
  input  logic       updn_mode,
  output ctrl_t      ctrl,
  output logic       irq
);
  ctrl_t ctrl_q, ctrl_d;
  logic  baud;

  assign baud = ctrl_q.rx_sel | ctrl_q.tx_sel;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = ctrl_t'(wdata);
    if (wrap && !baud) ctrl_d.ovf = 1'b1;
    if (ext_set) ctrl_d.ext = 1'b1;
    else if (wrap && updn_mode) ctrl_d.ext = ~ctrl_d.ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
  assign irq  = ctrl_q.ovf | (ctrl_q.ext & ~updn_mode);

  // R10: no hardware-set overflow flag while baud ticks are produced
  a_r10_no_ovf_in_baud: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !wr_en && !ctrl_q.ovf) |=> !ctrl_q.ovf);

  // R8 / R9: a trigger event outside up/down mode leaves the external flag set
  a_r8_ext_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_set && !updn_mode) |=> ctrl_q.ext);
endmodule

// File: rtl/crt_core.sv
module crt_core
  import crt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_t              ctrl,
  input  logic               tick_en,
  input  logic               cnt_fall,
  input  logic               trig_fall,
  input  logic               updn_en,
  input  logic               cnt_up,
  input  logic [CNT_W/8-1:0] cnt_wr,
  input  logic [CNT_W/8-1:0] cap_wr,
  input  logic [7:0]         wdata,
  output logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   cap,
  output logic               wrap,
  output logic               ext_set,
  output logic               updn_mode,
  output logic               rx_tick,
  output logic               tx_tick
);
  localparam int NB = CNT_W / 8;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, cnt_hw, cnt_d;
  logic [CNT_W-1:0] cap_q, cap_hw, cap_d;
  logic             half_q, half_d;
  logic             rx_q, tx_q, rx_d, tx_d;
  logic             baud, step, down, at_lim, reload_on_wrap;
  logic             trig_ok, trig_cap, trig_rl;

  always_comb begin
    baud           = ctrl.rx_sel | ctrl.tx_sel;
    updn_mode      = updn_en & ~ctrl.cap_sel & ~baud;
    half_d         = (ctrl.run & baud) ? ~half_q : 1'b0;
    if (baud)             step = ctrl.run & half_q;
    else if (ctrl.ct_sel) step = ctrl.run & cnt_fall;
    else                  step = ctrl.run & tick_en;
    down           = updn_mode & ~cnt_up;
    at_lim         = down ? (cnt_q == cap_q) : (cnt_q == MAXV);
    wrap           = step & at_lim;
    reload_on_wrap = ~ctrl.cap_sel | baud;
    trig_ok        = trig_fall & ctrl.ext_en & ~baud;
    trig_cap       = trig_ok & ctrl.cap_sel;
    trig_rl        = trig_ok & ~ctrl.cap_sel & ~updn_en;
    ext_set        = trig_cap | trig_rl;

    cnt_hw = cnt_q;
    if (trig_rl)        cnt_hw = cap_q;
    else if (wrap)      cnt_hw = down ? MAXV : (reload_on_wrap ? cap_q : '0);
    else if (step)      cnt_hw = down ? cnt_q - 1'b1 : cnt_q + 1'b1;

    cap_hw = trig_cap ? cnt_q : cap_q;
    rx_d   = wrap & baud & ctrl.rx_sel;
    tx_d   = wrap & baud & ctrl.tx_sel;
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign cnt_d[8*b +: 8] = cnt_wr[b] ? wdata : cnt_hw[8*b +: 8];
    assign cap_d[8*b +: 8] = cap_wr[b] ? wdata : cap_hw[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      half_q <= 1'b0;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      half_q <= half_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
    end
  end

  assign count   = cnt_q;
  assign cap     = cap_q;
  assign rx_tick = rx_q;
  assign tx_tick = tx_q;

  // R5: halted count holds unless software or a trigger reload loads it
  a_r5_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !trig_rl && cnt_wr == '0) |=> $stable(cnt_q));

  // R3: an ordinary up step adds exactly one
  a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !down && !at_lim && !trig_rl && cnt_wr == '0)
      |=> cnt_q == $past(cnt_q) + 1'b1);

  // R6: an up wrap in reload mode takes the capture/reload value
  a_r6_reload_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !down && reload_on_wrap && !trig_rl && cnt_wr == '0)
      |=> cnt_q == $past(cap_q));
endmodule

// File: rtl/crt_timer.sv
module crt_timer
  import crt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int STAGES  = 2,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick_en,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              updn_en,
  input  logic              cnt_up,
  output logic              irq,
  output logic              rx_tick,
  output logic              tx_tick
);
  localparam int NB       = CNT_W / 8;
  localparam int CAP_BASE = CNT_BASE + NB;

  logic             rst_meta_q, rst_n_i;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] count, cap;
  logic [NB-1:0]    cnt_wr, cap_wr;
  logic             ctrl_wr, cnt_fall, trig_fall, wrap, ext_set, updn_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_i    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_i    <= rst_meta_q;
    end
  end

  assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));

  for (genvar b = 0; b < NB; b++) begin : g_dec
    assign cnt_wr[b] = bus_we && (bus_addr == ADDR_W'(CNT_BASE + b));
    assign cap_wr[b] = bus_we && (bus_addr == ADDR_W'(CAP_BASE + b));
  end

  crt_edge_sync #(.STAGES(STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n_i), .pin(cnt_pin), .fall(cnt_fall));

  crt_edge_sync #(.STAGES(STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n_i), .pin(trig_pin), .fall(trig_fall));

  crt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .wr_en(ctrl_wr), .wdata(bus_wdata),
    .wrap(wrap), .ext_set(ext_set), .updn_mode(updn_mode),
    .ctrl(ctrl), .irq(irq));

  crt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n_i), .ctrl(ctrl), .tick_en(tick_en),
    .cnt_fall(cnt_fall), .trig_fall(trig_fall), .updn_en(updn_en),
    .cnt_up(cnt_up), .cnt_wr(cnt_wr), .cap_wr(cap_wr), .wdata(bus_wdata),
    .count(count), .cap(cap), .wrap(wrap), .ext_set(ext_set),
    .updn_mode(updn_mode), .rx_tick(rx_tick), .tx_tick(tx_tick));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) bus_rdata = ctrl;
    for (int i = 0; i < NB; i++) begin
      if (bus_addr == ADDR_W'(CNT_BASE + i)) bus_rdata = count[8*i +: 8];
      if (bus_addr == ADDR_W'(CAP_BASE + i)) bus_rdata = cap[8*i +: 8];
    end
  end

  // R10: a receive tick only follows a cycle with the receive select set
  a_r10_rx_source: assert property (@(posedge clk) disable iff (!rst_n_i)
    rx_tick |-> $past(ctrl.rx_sel));
endmodule

// File: tb/sim_crt_timer.sv
`timescale 1ns/1ps
module sim_crt_timer;
  logic       clk = 1'b0;
  logic       rst_n, bus_we, tick_en, cnt_pin, trig_pin, updn_en, cnt_up;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq, rx_tick, tx_tick;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  crt_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .cnt_pin(cnt_pin), .trig_pin(trig_pin), .updn_en(updn_en),
    .cnt_up(cnt_up), .irq(irq), .rx_tick(rx_tick), .tx_tick(tx_tick));

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] cap;
    logic [15:0] cnt;
    logic        updn;
    logic        up;
    logic [7:0]  n;
    logic [15:0] exp_cnt;
    logic [7:0]  exp_ctrl;
    logic        exp_irq;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{8'h05, 16'h0000, 16'h0010, 1'b0, 1'b1, 8'd5,  16'h0015, 8'h05, 1'b0}, // R3
    '{8'h05, 16'h0000, 16'hFFFE, 1'b0, 1'b1, 8'd3,  16'h0001, 8'h85, 1'b1}, // R6 capture wrap
    '{8'h04, 16'h1234, 16'hFFFF, 1'b0, 1'b1, 8'd2,  16'h1235, 8'h84, 1'b1}, // R6 reload wrap
    '{8'h04, 16'h0100, 16'h0102, 1'b1, 1'b0, 8'd4,  16'hFFFE, 8'hC4, 1'b1}, // R7 down wrap
    '{8'h04, 16'h0200, 16'hFFFF, 1'b1, 1'b1, 8'd1,  16'h0200, 8'hC4, 1'b1}, // R7 up wrap
    '{8'h01, 16'h0000, 16'h4321, 1'b0, 1'b1, 8'd10, 16'h4321, 8'h01, 1'b0}, // R5 halted
    '{8'h04, 16'h0007, 16'h0009, 1'b1, 1'b0, 8'd2,  16'h0007, 8'h04, 1'b0}  // R7 down no wrap
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic setup(input logic [7:0] c, input logic [15:0] cp, input logic [15:0] cn);
    wr(3'd0, 8'h00);
    wr(3'd3, cp[7:0]); wr(3'd4, cp[15:8]);
    wr(3'd1, cn[7:0]); wr(3'd2, cn[15:8]);
    wr(3'd0, c);
  endtask

  task automatic pin_fall(input bit trig);
    if (trig) trig_pin = 1'b0; else cnt_pin = 1'b0;
    repeat (3) @(negedge clk);
    if (trig) trig_pin = 1'b1; else cnt_pin = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    int          nrx, ntx;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    tick_en = 1'b0; cnt_pin = 1'b1; trig_pin = 1'b1; updn_en = 1'b0; cnt_up = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd0, b); chk("R1 ctrl in reset", b, 8'h00);
    chk("R1 irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd0, b);  chk("R1 ctrl", b, 8'h00);
    rd16(3'd1, w); chk("R1 count", w, 16'h0000);
    rd16(3'd3, w); chk("R1 cap", w, 16'h0000);
    chk("R1 outputs", {irq, rx_tick, tx_tick}, 3'b000);

    // R2 register read-back
    setup(8'h0B, 16'hBEEF, 16'hCAFE);
    rd(3'd0, b);  chk("R2 ctrl readback", b, 8'h0B);
    rd16(3'd1, w); chk("R2 count readback", w, 16'hCAFE);
    rd16(3'd3, w); chk("R2 cap readback", w, 16'hBEEF);

    // vector table: R3 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 8'h00);
      updn_en = VEC[i].updn; cnt_up = VEC[i].up;
      setup(VEC[i].ctrl, VEC[i].cap, VEC[i].cnt);
      tick_en = 1'b1;
      repeat (VEC[i].n) @(negedge clk);
      tick_en = 1'b0;
      rd16(3'd1, w); chk($sformatf("vector %0d count (R3 R5 R6 R7)", i), w, VEC[i].exp_cnt);
      rd(3'd0, b);   chk($sformatf("vector %0d ctrl (R6 R7)", i), b, VEC[i].exp_ctrl);
      chk($sformatf("vector %0d irq (R11)", i), irq, VEC[i].exp_irq);
    end

    // R11 / R7: external flag masked from irq in up/down mode
    updn_en = 1'b1; cnt_up = 1'b1;
    wr(3'd0, 8'h44);
    chk("R7 ext masked in up/down", irq, 1'b0);
    updn_en = 1'b0;
    #0.1;
    chk("R11 ext drives irq", irq, 1'b1);
    wr(3'd0, 8'h80); chk("R11 sw ovf write", irq, 1'b1);
    wr(3'd0, 8'h00); chk("R11 cleared", irq, 1'b0);

    // R4 counter mode on count pin, tick_en ignored
    setup(8'h06, 16'h0000, 16'h0000);
    tick_en = 1'b1;
    pin_fall(1'b0); pin_fall(1'b0); pin_fall(1'b0);
    tick_en = 1'b0;
    repeat (2) @(negedge clk);
    rd16(3'd1, w); chk("R4 pin edges counted", w, 16'h0003);

    // R8 capture on trigger
    setup(8'h0D, 16'h0000, 16'hABCD);
    pin_fall(1'b1);
    rd16(3'd3, w); chk("R8 capture value", w, 16'hABCD);
    rd(3'd0, b);   chk("R8 ext flag", b, 8'h4D);
    chk("R8 irq", irq, 1'b1);

    // R9 reload on trigger
    setup(8'h0C, 16'h5555, 16'h0001);
    pin_fall(1'b1);
    rd16(3'd1, w); chk("R9 reload value", w, 16'h5555);
    rd(3'd0, b);   chk("R9 ext flag", b, 8'h4C);

    // R9 trigger ignored with trigger enable clear
    setup(8'h05, 16'h1111, 16'h2222);
    pin_fall(1'b1);
    rd16(3'd3, w); chk("R9 no capture", w, 16'h1111);
    rd16(3'd1, w); chk("R9 count kept", w, 16'h2222);
    rd(3'd0, b);   chk("R9 no flag", b, 8'h05);

    // R10 baud mode on both ticks
    setup(8'h34, 16'hFFFE, 16'hFFFE);
    nrx = 0; ntx = 0;
    tick_en = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      nrx += int'(rx_tick); ntx += int'(tx_tick);
    end
    tick_en = 1'b0;
    chk("R10 rx ticks", nrx, 10);
    chk("R10 tx ticks", ntx, 10);
    rd16(3'd1, w); chk("R10 reloaded count", w, 16'hFFFE);
    rd(3'd0, b);   chk("R10 no ovf", b, 8'h34);

    // R10 receive-only
    setup(8'h24, 16'hFFFE, 16'hFFFE);
    nrx = 0; ntx = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      nrx += int'(rx_tick); ntx += int'(tx_tick);
    end
    chk("R10 rx only ticks", nrx, 10);
    chk("R10 tx silent", ntx, 0);
    chk("R10 irq quiet", irq, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule